// File: doc/BRIEF.md
# Multi-Core Auto-Masking Interrupt Controller

The block gathers a set of level-sensitive hardware interrupt lines and a pair of inter-processor interrupt (IPI) flags per core. It drives one interrupt output per core. Each line has one mask bit, a software-trigger bit that is ORed with its input, and an affinity field that picks the cores it reaches. There are no priority fields. The lowest pending line number always wins, and both IPIs of a core outrank every hardware line.

Each core has a single event register. Reading it returns the core's best pending event, and the same read acknowledges that event. A hardware line is acknowledged by setting its mask bit, so software re-enables the line by clearing the mask. An IPI is acknowledged by clearing its flag. All registers sit behind a simple register port that carries the index of the accessing core. A local window always resolves to that core, and explicit windows reach any chosen core.

Top module: `irq_automask_ctrl`

## Requirements
- R1: After reset, all lines are masked, all software triggers are 0, every affinity field is 1 (core 0 only), no IPI is pending, `irq_out` is 0, and an event read returns 0.
- R2: Line l is pending while (`hw_irq[l]` OR its software trigger) is 1 and its mask bit is 0. `irq_out[c]` follows pending state routed to core c in the same cycle the state or input changes.
- R3: Writing offset 0x000 sets the mask bits that are 1 in the write data. Writing offset 0x004 clears them. Reading either offset returns the mask word, with bit l standing for line l.
- R4: Writing offset 0x008 sets software-trigger bits and writing offset 0x00C clears them. Reading either offset returns the trigger word. A set trigger makes its line pending even when the hardware input is low.
- R5: The affinity word of line l is at offset 0x100 + 4*l. Bit c routes the line to core c. Several set bits route it to several cores, and a value of 0 routes it nowhere.
- R6: An event read returns bit 31 = 1 for a present event, bit 16 = type (0 for a hardware line, 1 for an IPI), and bits 15:0 = number (the line, or 0 for the self IPI and 1 for the other IPI). Priority order is self IPI, then other IPI, then the lowest line number. With nothing pending the read returns 0.
- R7: An event read that returns a hardware line sets that line's mask bit. One that returns an IPI clears that IPI flag. The core's `irq_out` drops from the clock edge that takes the read if nothing else is pending.
- R8: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the request edge. Writes produce no `bus_rvalid`.
- R9: The per-core window at 0x200 maps to the core named by `bus_core`. The window at 0x400 + 0x10*k maps to core k whatever the value of `bus_core`. Inside a window, +0x0 is the event register, +0x4 sends an IPI, and +0x8 raises the self IPI.
- R10: Writing a core index to +0x4 raises the "other" IPI of that core, and an index of NCORES or more is ignored. Writing 1 in bit 0 to +0x8 raises the window core's self IPI. Reading +0x4 or +0x8 returns {other, self} of the window core.
- R11: A write to the event register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | NLINES | Level-sensitive hardware lines, active high |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_core | input | CW | Index of the core making the access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq_out | output | NCORES | Interrupt request per core |

## Verification
`irq_out` is a combinational function of the register state and `hw_irq`. It is therefore checked one time step after an input change made at the falling edge, or at the falling edge after the rising edge that took a register write or an event read. Read data is due one rising edge after the request. The bench pushes each expected read value into a queue when it issues the read. A monitor then pops and compares the value at the first falling edge where `bus_rvalid` is high, so each result is compared in exactly the cycle it becomes due.

// File: rtl/iac_pkg.sv
// Shared constants and types for the auto-masking interrupt controller.
// Assumes byte addressing with 32-bit registers.
package iac_pkg;
    // Global register offsets
    localparam int OFF_MASK_SET = 'h000;
    localparam int OFF_MASK_CLR = 'h004;
    localparam int OFF_SWT_SET  = 'h008;
    localparam int OFF_SWT_CLR  = 'h00C;
    localparam int AFF_BASE     = 'h100;
    // Per-core windows
    localparam int LOCAL_BASE   = 'h200;
    localparam int EXPL_BASE    = 'h400;
    // Offsets inside a per-core window (word index)
    localparam logic [1:0] WIN_EVENT = 2'd0;
    localparam logic [1:0] WIN_SEND  = 2'd1;
    localparam logic [1:0] WIN_SELF  = 2'd2;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_HW    = 2'd1,
        EV_SELF  = 2'd2,
        EV_OTHER = 2'd3
    } ev_kind_t;
endpackage

// File: rtl/iac_prio_pick.sv
// Fixed-priority picker: reports whether any request bit is set and the
// index of the lowest set bit. Purely combinational.
module iac_prio_pick #(
    parameter int W  = 32,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one assigned
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/iac_core_sel.sv
// Per-core event selector: ranks the self IPI, then the other IPI, then the
// lowest routed hardware line. Builds the event word and the core's request.
// Assumes line_req is already qualified by mask and affinity.
module iac_core_sel
    import iac_pkg::*;
#(
    parameter int NLINES = 32,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] line_req,
    input  logic              ipi_self,
    input  logic              ipi_other,
    output ev_kind_t          ev_kind,
    output logic [LW-1:0]     ev_line,
    output logic [31:0]       ev_word,
    output logic              irq
);
    logic          hw_found;
    logic [LW-1:0] hw_idx;

    iac_prio_pick #(.W(NLINES)) u_pick (
        .req   (line_req),
        .found (hw_found),
        .idx   (hw_idx)
    );

    // Choose the winning event and encode it
    always_comb begin
        ev_line = hw_idx;
        if (ipi_self) begin
            ev_kind = EV_SELF;
            ev_word = 32'h8001_0000;
        end else if (ipi_other) begin
            ev_kind = EV_OTHER;
            ev_word = 32'h8001_0001;
        end else if (hw_found) begin
            ev_kind = EV_HW;
            ev_word = {1'b1, 15'd0, 16'(hw_idx)};
        end else begin
            ev_kind = EV_NONE;
            ev_word = 32'd0;
        end
    end

    // Request to the core whenever any event is waiting
    assign irq = ipi_self | ipi_other | hw_found;
endmodule

// File: rtl/irq_automask_ctrl.sv
// Auto-masking interrupt controller top. Holds mask, software trigger,
// affinity and IPI state, decodes the register port and acknowledges
// events on read. Assumes NLINES <= 32 and one access per cycle.
module irq_automask_ctrl
    import iac_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 32,
    parameter int ADDR_W = 12,
    localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] hw_irq,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [CW-1:0]     bus_core,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic [NCORES-1:0] irq_out
);
    localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFF_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFF_MASK_CLR);
    localparam logic [ADDR_W-1:0] A_SSET  = ADDR_W'(OFF_SWT_SET);
    localparam logic [ADDR_W-1:0] A_SCLR  = ADDR_W'(OFF_SWT_CLR);
    localparam logic [ADDR_W-1:0] A_AFF   = ADDR_W'(AFF_BASE);
    localparam logic [ADDR_W-1:0] A_LOC   = ADDR_W'(LOCAL_BASE);
    localparam logic [ADDR_W-1:0] A_EXP   = ADDR_W'(EXPL_BASE);
    localparam logic [ADDR_W-3:0] N_LINES = (ADDR_W-2)'(NLINES);
    localparam logic [ADDR_W-5:0] N_CORES = (ADDR_W-4)'(NCORES);
    localparam logic [CW:0]       N_CW    = (CW+1)'(NCORES);

    logic [NLINES-1:0] mask_q, swt_q;
    logic [NCORES-1:0] aff_q [NLINES];
    logic [NCORES-1:0] ipi_self_q, ipi_other_q;
    logic [31:0]       rdata_q;
    logic              rvalid_q;

    logic [NLINES-1:0] pend_w;
    ev_kind_t          ev_kind [NCORES];
    logic [LW-1:0]     ev_line [NCORES];
    logic [31:0]       ev_word [NCORES];

    // Lines pending before routing: either source, not masked
    assign pend_w = (hw_irq | swt_q) & ~mask_q;

    // One selector per core on its affinity column
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [NLINES-1:0] col;
        for (genvar l = 0; l < NLINES; l++) begin : g_col
            assign col[l] = aff_q[l][c];
        end
        iac_core_sel #(.NLINES(NLINES)) u_sel (
            .line_req  (pend_w & col),
            .ipi_self  (ipi_self_q[c]),
            .ipi_other (ipi_other_q[c]),
            .ev_kind   (ev_kind[c]),
            .ev_line   (ev_line[c]),
            .ev_word   (ev_word[c]),
            .irq       (irq_out[c])
        );
    end

    // Address decode
    logic [ADDR_W-1:0] aff_rel, exp_rel;
    logic              is_aff, is_loc, is_exp, is_win, core_ok;
    logic [LW-1:0]     aff_idx;
    logic [CW-1:0]     tgt_core;
    logic [1:0]        win_off;

    // Classify the address and pick the window core
    always_comb begin
        aff_rel  = bus_addr - A_AFF;
        exp_rel  = bus_addr - A_EXP;
        is_aff   = (bus_addr >= A_AFF) && (aff_rel[ADDR_W-1:2] < N_LINES);
        aff_idx  = aff_rel[LW+1:2];
        is_loc   = (bus_addr[ADDR_W-1:4] == A_LOC[ADDR_W-1:4]);
        is_exp   = (bus_addr >= A_EXP) && (exp_rel[ADDR_W-1:4] < N_CORES);
        tgt_core = is_loc ? bus_core : exp_rel[CW+3:4];
        core_ok  = ({1'b0, tgt_core} < N_CW);
        is_win   = (is_loc || is_exp) && core_ok;
        win_off  = bus_addr[3:2];
    end

    logic        rd_ev, wr_acc;
    logic [31:0] rd_mux;
    assign rd_ev  = bus_valid && !bus_write && is_win && (win_off == WIN_EVENT);
    assign wr_acc = bus_valid && bus_write;

    // Read data selection
    always_comb begin
        rd_mux = 32'd0;
        if (bus_addr == A_MSET || bus_addr == A_MCLR) rd_mux = 32'(mask_q);
        else if (bus_addr == A_SSET || bus_addr == A_SCLR) rd_mux = 32'(swt_q);
        else if (is_aff) rd_mux = 32'(aff_q[aff_idx]);
        else if (is_win) begin
            if (win_off == WIN_EVENT) rd_mux = ev_word[tgt_core];
            else if (win_off == WIN_SEND || win_off == WIN_SELF)
                rd_mux = {30'd0, ipi_other_q[tgt_core], ipi_self_q[tgt_core]};
        end
    end

    // State update: register writes, read response and acknowledge on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '1;
            swt_q       <= '0;
            ipi_self_q  <= '0;
            ipi_other_q <= '0;
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
            for (int l = 0; l < NLINES; l++) aff_q[l] <= NCORES'(1);
        end else begin
            rvalid_q <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) rdata_q <= rd_mux;
            if (wr_acc) begin
                if (bus_addr == A_MSET) mask_q <= mask_q | bus_wdata[NLINES-1:0];
                if (bus_addr == A_MCLR) mask_q <= mask_q & ~bus_wdata[NLINES-1:0];
                if (bus_addr == A_SSET) swt_q  <= swt_q | bus_wdata[NLINES-1:0];
                if (bus_addr == A_SCLR) swt_q  <= swt_q & ~bus_wdata[NLINES-1:0];
                if (is_aff) aff_q[aff_idx] <= bus_wdata[NCORES-1:0];
                if (is_win && win_off == WIN_SELF && bus_wdata[0])
                    ipi_self_q[tgt_core] <= 1'b1;
                if (is_win && win_off == WIN_SEND && bus_wdata < 32'(NCORES))
                    ipi_other_q[bus_wdata[CW-1:0]] <= 1'b1;
            end
            if (rd_ev) begin
                unique case (ev_kind[tgt_core])
                    EV_HW:    mask_q[ev_line[tgt_core]] <= 1'b1;
                    EV_SELF:  ipi_self_q[tgt_core]      <= 1'b0;
                    EV_OTHER: ipi_other_q[tgt_core]     <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/iac_chk.sv
// Assertion checker for irq_automask_ctrl, attached by bind below.
// Observes ports and the mask, trigger and IPI state.
module iac_chk #(
    parameter int NCORES = 4,
    parameter int NLINES = 32,
    parameter int ADDR_W = 12,
    localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rvalid,
    input logic [31:0]       bus_rdata,
    input logic [NCORES-1:0] irq_out,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] swt_q,
    input logic [NCORES-1:0] ipi_self_q,
    input logic [NCORES-1:0] ipi_other_q
);
    logic evt_rd_q;
    logic evt_addr;

    // Event-register address: local window or any explicit window, offset 0
    assign evt_addr = (bus_addr == ADDR_W'('h200)) ||
                      ((bus_addr >= ADDR_W'('h400)) && (bus_addr[3:0] == 4'd0) &&
                       (bus_addr < ADDR_W'('h400 + 16 * NCORES)));

    // Remember that the response now due belongs to an event read
    always_ff @(posedge clk) begin
        if (!rst_n) evt_rd_q <= 1'b0;
        else        evt_rd_q <= bus_valid && !bus_write && evt_addr;
    end

    // R7
    automask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && evt_rd_q && bus_rdata[31] && !bus_rdata[16])
            |-> mask_q[bus_rdata[LW-1:0]]);

    // R8
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mask_q) && ipi_self_q == '0 && ipi_other_q == '0) |-> (irq_out == '0));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'('h000))
            |=> ((mask_q & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

    // R4
    swt_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'('h008)) |=> $stable(mask_q));

    // R11
    evt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && evt_addr)
            |=> ($stable(mask_q) && $stable(swt_q) && $stable(ipi_self_q)));
endmodule

bind irq_automask_ctrl iac_chk #(
    .NCORES (NCORES),
    .NLINES (NLINES),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rvalid  (bus_rvalid),
    .bus_rdata   (bus_rdata),
    .irq_out     (irq_out),
    .mask_q      (mask_q),
    .swt_q       (swt_q),
    .ipi_self_q  (ipi_self_q),
    .ipi_other_q (ipi_other_q)
);

// File: tb/irq_automask_ctrl_tb.sv
// Scoreboard bench: the read task queues the expected value, and a monitor
// compares it when bus_rvalid shows up at a falling edge.
module irq_automask_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCORES = 4;
    localparam int NLINES = 32;
    localparam int ADDR_W = 12;
    localparam int CW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NLINES-1:0] hw_irq = '0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [CW-1:0]     bus_core = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [31:0]       bus_rdata;
    logic [NCORES-1:0] irq_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    irq_automask_ctrl #(.NCORES(NCORES), .NLINES(NLINES), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_core(bus_core),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int core, int addr, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_core = CW'(core); bus_addr = ADDR_W'(addr); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(int core, int addr, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_core = CW'(core); bus_addr = ADDR_W'(addr);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_hw(int line, logic v);
        hw_irq[line] = v;
        #1;
    endtask

    // Monitor: compare each read response with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R8 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
        rd(0, 'h000, 32'hFFFF_FFFF, "R1 mask after reset");
        rd(0, 'h00C, 32'h0, "R1 swt after reset");
        rd(0, 'h114, 32'h1, "R1 affinity after reset");
        rd(0, 'h200, 32'h0, "R1 event after reset");

        // R2 level input gated by mask
        set_hw(5, 1'b1);
        chk("R2 masked line quiet", 32'(irq_out), 32'h0);
        wr(0, 'h004, 32'h20);
        chk("R2 unmasked line raises core0", 32'(irq_out), 32'h1);
        rd(0, 'h004, 32'hFFFF_FFDF, "R3 mask readback");

        // R6/R7 priority and auto-mask
        set_hw(3, 1'b1);
        wr(0, 'h004, 32'h08);
        rd(0, 'h200, 32'h8000_0003, "R6 lowest line first");
        chk("R7 next line still pending", 32'(irq_out), 32'h1);
        rd(0, 'h200, 32'h8000_0005, "R7 acked line masked");
        chk("R7 irq drops after ack", 32'(irq_out), 32'h0);
        rd(0, 'h000, 32'hFFFF_FFFF, "R7 mask bits set by ack");
        set_hw(3, 1'b0); set_hw(5, 1'b0);

        // R4/R5/R9 software trigger, affinity, explicit window
        wr(0, 'h11C, 32'h4);
        wr(0, 'h004, 32'h80);
        chk("R4 no trigger yet", 32'(irq_out), 32'h0);
        wr(0, 'h008, 32'h80);
        chk("R5 trigger routed to core2", 32'(irq_out), 32'h4);
        rd(0, 'h008, 32'h80, "R4 trigger readback");
        rd(0, 'h420, 32'h8000_0007, "R9 explicit window core2");
        chk("R7 core2 quiet after ack", 32'(irq_out), 32'h0);
        wr(0, 'h00C, 32'h80);
        rd(0, 'h00C, 32'h0, "R4 trigger cleared");

        // R5 multi-core and zero affinity
        wr(0, 'h124, 32'h3);
        wr(0, 'h004, 32'h200);
        set_hw(9, 1'b1);
        chk("R5 line to cores 0 and 1", 32'(irq_out), 32'h3);
        rd(1, 'h200, 32'h8000_0009, "R9 local window core1");
        chk("R7 shared line masked for all", 32'(irq_out), 32'h0);
        wr(0, 'h128, 32'h0);
        wr(0, 'h004, 32'h400);
        set_hw(10, 1'b1);
        chk("R5 zero affinity routes nowhere", 32'(irq_out), 32'h0);
        rd(0, 'h128, 32'h0, "R5 affinity readback");

        // R10 IPIs and R6 IPI ranking
        wr(0, 'h204, 32'h3);
        chk("R10 send raises core3", 32'(irq_out), 32'h8);
        wr(3, 'h208, 32'h1);
        wr(0, 'h12C, 32'h8);
        wr(0, 'h004, 32'h800);
        set_hw(11, 1'b1);
        rd(3, 'h204, 32'h3, "R10 ipi status core3");
        rd(3, 'h200, 32'h8001_0000, "R6 self IPI first");
        rd(0, 'h430, 32'h8001_0001, "R6 other IPI second");
        rd(3, 'h200, 32'h8000_000B, "R6 hw after IPIs");
        rd(3, 'h200, 32'h0, "R6 nothing pending");
        chk("R7 core3 quiet", 32'(irq_out), 32'h0);
        wr(0, 'h204, 32'h7);
        chk("R10 out-of-range send ignored", 32'(irq_out), 32'h0);
        rd(0, 'h438, 32'h0, "R10 core3 no IPI after bad send");

        // R11 write to event register
        wr(0, 'h004, 32'h1000);
        set_hw(12, 1'b1);
        wr(0, 'h200, 32'hFFFF_FFFF);
        chk("R11 event write no effect", 32'(irq_out), 32'h1);
        rd(0, 'h200, 32'h8000_000C, "R11 event intact");

        // R3 mask set
        wr(0, 'h004, 32'h2000);
        set_hw(13, 1'b1);
        chk("R3 line13 pending", 32'(irq_out), 32'h1);
        wr(0, 'h000, 32'h2000);
        chk("R3 mask set silences", 32'(irq_out), 32'h0);
        rd(0, 'h004, 32'hFFFF_FBFF, "R3 mask word");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R8 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule